// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Arbiter

This block decides, every cycle, whether a processor core should be interrupted and on which of eight priority levels. Level 0 is the most urgent and level 7 the least. Each device request line is routed to a level by a small per-device assignment register. Routing a device to level 0 disconnects it. Several devices may share a level. A request counts only when three conditions hold: the whole interrupt system is switched on, the level is unmasked, and no level of equal or higher priority is being serviced.

The core sees a pending flag, the winning level and a dispatch address. The address is octal 040 plus twice the level, so each level owns two words. When the core accepts, the level's hold bit is set. That level, and every level below it, stays blocked until the core issues a dismiss. A dismiss releases the most urgent held level, so nested service unwinds in order. A software write port sets or clears mask bits and switches the system on or off. The mask, hold and system-enable state are visible at all times on read-back outputs.

Top module: `prioIntCtrl`

## Requirements
- R1: After reset the system enable is 0, mask bits 1..7 are 0, all hold bits are 0, every device is assigned level 0, and no interrupt is pending.
- R2: Level 0 has no mask bit: bit 0 of the mask read-back always reads 1, and a clear-mask write to bit 0 has no effect.
- R3: A device whose assignment register (written through `cfgWrEn`/`cfgDev`/`cfgLevel`) holds 0 never causes a request. Writing 1..7 routes it to that level from the next cycle.
- R4: A level is requesting when any device assigned to it asserts its request line.
- R5: A requesting level is recognized only when the system enable is 1, its mask bit is 1, and no hold bit at its own or any higher-priority (lower-numbered) level is set.
- R6: When several levels are recognized, `intLevel` is the lowest-numbered one and `intAddr` equals 32 + 2*`intLevel` (octal 040 + 2n). `intPending` is 1 exactly when some level is recognized.
- R7: An `ackStrobe` while `intPending` is 1 sets the hold bit of `intLevel` at the next edge. An `ackStrobe` with nothing pending changes nothing.
- R8: While a level is held, requests on that level and on every lower-priority level are not recognized, while higher-priority levels still are.
- R9: A `dismissStrobe` clears only the lowest-numbered set hold bit. With no hold bit set it does nothing.
- R10: On a register write, `regSetMask` sets and `regClrMask` clears mask bits 1..7, and clear wins when both target one bit. `regSysOn` switches the system on and `regSysOff` switches it off, and off wins when both are given.
- R11: `regMask`, `regHold` and `regSysEn` reflect the registered state in the cycle after each change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | NUM_DEV | Device request lines |
| cfgWrEn | input | 1 | Write strobe for a device level assignment |
| cfgDev | input | DEV_W | Device index being assigned |
| cfgLevel | input | 3 | Level given to that device (0 = disconnected) |
| regWrEn | input | 1 | Software register write strobe |
| regSetMask | input | 8 | Mask bits to set (bit 0 ignored) |
| regClrMask | input | 8 | Mask bits to clear (bit 0 ignored) |
| regSysOn | input | 1 | Switch interrupt system on |
| regSysOff | input | 1 | Switch interrupt system off |
| ackStrobe | input | 1 | Core accepts the pending interrupt |
| dismissStrobe | input | 1 | Core finishes servicing the most urgent held level |
| regMask | output | 8 | Mask read-back, bit 0 always 1 |
| regHold | output | 8 | Hold read-back |
| regSysEn | output | 1 | System enable read-back |
| intPending | output | 1 | An interrupt is recognized |
| intLevel | output | 3 | Winning level |
| intAddr | output | ADDR_W | Dispatch address of the winning level |

## Verification
The bench nests two service levels and then unwinds them. A dismiss that cleared the wrong hold bit, or cleared every bit, would leave the wrong hold pattern and would lift blocking on a level too early. It also drives a held level's own request and a lower level's request at the same time. A blocking compare that used strict instead of non-strict priority would re-raise the held level. It assigns a device to level 0 while that device is requesting, so a router that treated 0 as an ordinary level would flag an interrupt. Writes that set and clear the same mask bit, or switch the system on and off together, expose any reversed precedence. An accept with nothing pending must leave the hold register untouched.

// File: rtl/picPkg.sv
package picPkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef struct packed {
    logic             setHold;
    logic [LVL_W-1:0] setLvl;
    logic             clrHold;
    logic [LVL_W-1:0] clrLvl;
  } holdStrb_t;
endpackage

// File: rtl/picDatapath.sv
module picDatapath
  import picPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               cfgWrEn,
  input  logic [DEV_W-1:0]   cfgDev,
  input  logic [LVL_W-1:0]   cfgLevel,
  input  logic               regWrEn,
  input  logic [NUM_LVL-1:0] regSetMask,
  input  logic [NUM_LVL-1:0] regClrMask,
  input  logic               regSysOn,
  input  logic               regSysOff,
  input  holdStrb_t          strb,
  output logic [NUM_LVL-1:0] reqVec,
  output logic [NUM_LVL-1:0] maskEff,
  output logic [NUM_LVL-1:0] holdQ,
  output logic               sysEnQ
);
  logic [LVL_W-1:0]   asgQ [NUM_DEV];
  logic [NUM_LVL-1:1] maskQ;
  logic [NUM_LVL-1:0] holdNext;

  // Device-to-level assignment registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < NUM_DEV; d++) asgQ[d] <= '0;
    end else if (cfgWrEn) begin
      asgQ[cfgDev] <= cfgLevel;
    end
  end

  // Per-level request vector; level 0 cannot be reached by any device
  assign reqVec[0] = 1'b0;
  generate
    for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvlReq
      always_comb begin
        reqVec[l] = 1'b0;
        for (int d = 0; d < NUM_DEV; d++)
          if (devReq[d] && (asgQ[d] == LVL_W'(l))) reqVec[l] = 1'b1;
      end
    end
  endgenerate

  // Mask and system enable, clear/off take precedence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      sysEnQ <= 1'b0;
    end else if (regWrEn) begin
      maskQ  <= (maskQ | regSetMask[NUM_LVL-1:1]) & ~regClrMask[NUM_LVL-1:1];
      if (regSysOff)     sysEnQ <= 1'b0;
      else if (regSysOn) sysEnQ <= 1'b1;
    end
  end

  assign maskEff = {maskQ, 1'b1};

  // Hold register
  always_comb begin
    holdNext = holdQ;
    if (strb.clrHold) holdNext[strb.clrLvl] = 1'b0;
    if (strb.setHold) holdNext[strb.setLvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdQ <= '0;
    else       holdQ <= holdNext;
  end

  assert_hold_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setHold |=> holdQ[$past(strb.setLvl)]);

  assert_dismiss_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrHold && !strb.setHold) |=>
      (!holdQ[$past(strb.clrLvl)] && ($countones(holdQ) + 1 == $countones($past(holdQ)))));

  assert_sys_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSysOff) |=> !sysEnQ);

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regClrMask[1]) |=> !maskEff[1]);
endmodule

// File: rtl/picCtrl.sv
module picCtrl
  import picPkg::*;
#(
  parameter int            ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'o40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LVL-1:0] reqVec,
  input  logic [NUM_LVL-1:0] maskEff,
  input  logic [NUM_LVL-1:0] holdQ,
  input  logic               sysEnQ,
  input  logic               ackStrobe,
  input  logic               dismissStrobe,
  output holdStrb_t          strb,
  output logic               intPending,
  output logic [LVL_W-1:0]   intLevel,
  output logic [ADDR_W-1:0]  intAddr
);
  logic [NUM_LVL-1:0] blocked;
  logic [NUM_LVL-1:0] eligible;
  logic [LVL_W-1:0]   topHeld;

  // A level is blocked when it or any more urgent level is held
  always_comb begin
    blocked[0] = holdQ[0];
    for (int l = 1; l < NUM_LVL; l++) blocked[l] = blocked[l-1] | holdQ[l];
  end

  assign eligible = reqVec & maskEff & ~blocked & {NUM_LVL{sysEnQ}};

  always_comb begin
    intLevel = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (eligible[l]) intLevel = LVL_W'(l);
  end

  always_comb begin
    topHeld = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (holdQ[l]) topHeld = LVL_W'(l);
  end

  assign intPending = |eligible;
  assign intAddr    = BASE_ADDR + ADDR_W'({intLevel, 1'b0});

  always_comb begin
    strb.setHold = ackStrobe && intPending;
    strb.setLvl  = intLevel;
    strb.clrHold = dismissStrobe && (|holdQ);
    strb.clrLvl  = topHeld;
  end

  function automatic logic heldAtOrAbove(logic [NUM_LVL-1:0] h, logic [LVL_W-1:0] lv);
    logic r = 1'b0;
    for (int i = 0; i < NUM_LVL; i++)
      if (i <= int'(lv) && h[i]) r = 1'b1;
    return r;
  endfunction

  assert_sys_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> sysEnQ);

  assert_winner_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> (reqVec[intLevel] && maskEff[intLevel]));

  assert_no_held_above_R8: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> !heldAtOrAbove(holdQ, intLevel));

  assert_strb_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrHold |-> holdQ[strb.clrLvl]);
endmodule

// File: rtl/prioIntCtrl.sv
module prioIntCtrl
  import picPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'o40,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               cfgWrEn,
  input  logic [DEV_W-1:0]   cfgDev,
  input  logic [2:0]         cfgLevel,
  input  logic               regWrEn,
  input  logic [7:0]         regSetMask,
  input  logic [7:0]         regClrMask,
  input  logic               regSysOn,
  input  logic               regSysOff,
  input  logic               ackStrobe,
  input  logic               dismissStrobe,
  output logic [7:0]         regMask,
  output logic [7:0]         regHold,
  output logic               regSysEn,
  output logic               intPending,
  output logic [2:0]         intLevel,
  output logic [ADDR_W-1:0]  intAddr
);
  holdStrb_t          strb;
  logic [NUM_LVL-1:0] reqVec;
  logic [NUM_LVL-1:0] maskEff;
  logic [NUM_LVL-1:0] holdQ;
  logic               sysEnQ;

  picDatapath #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_dp (
    .clk(clk), .rstN(rstN), .devReq(devReq),
    .cfgWrEn(cfgWrEn), .cfgDev(cfgDev), .cfgLevel(cfgLevel),
    .regWrEn(regWrEn), .regSetMask(regSetMask), .regClrMask(regClrMask),
    .regSysOn(regSysOn), .regSysOff(regSysOff), .strb(strb),
    .reqVec(reqVec), .maskEff(maskEff), .holdQ(holdQ), .sysEnQ(sysEnQ)
  );

  picCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .maskEff(maskEff),
    .holdQ(holdQ), .sysEnQ(sysEnQ), .ackStrobe(ackStrobe),
    .dismissStrobe(dismissStrobe), .strb(strb), .intPending(intPending),
    .intLevel(intLevel), .intAddr(intAddr)
  );

  assign regMask  = maskEff;
  assign regHold  = holdQ;
  assign regSysEn = sysEnQ;

  assert_lvl0_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    regMask[0]);
endmodule

// File: tb/prioIntCtrl_bench.sv
module prioIntCtrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] devReq = '0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgDev = '0;
  logic [2:0] cfgLevel = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regSetMask = '0;
  logic [7:0] regClrMask = '0;
  logic       regSysOn = 1'b0;
  logic       regSysOff = 1'b0;
  logic       ackStrobe = 1'b0;
  logic       dismissStrobe = 1'b0;
  logic [7:0] regMask;
  logic [7:0] regHold;
  logic       regSysEn;
  logic       intPending;
  logic [2:0] intLevel;
  logic [5:0] intAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prioIntCtrl u_prioIntCtrl (
    .clk(clk), .rstN(rstN), .devReq(devReq), .cfgWrEn(cfgWrEn),
    .cfgDev(cfgDev), .cfgLevel(cfgLevel), .regWrEn(regWrEn),
    .regSetMask(regSetMask), .regClrMask(regClrMask), .regSysOn(regSysOn),
    .regSysOff(regSysOff), .ackStrobe(ackStrobe), .dismissStrobe(dismissStrobe),
    .regMask(regMask), .regHold(regHold), .regSysEn(regSysEn),
    .intPending(intPending), .intLevel(intLevel), .intAddr(intAddr)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] s, logic [7:0] c, logic on, logic off);
    @(negedge clk);
    regWrEn = 1'b1; regSetMask = s; regClrMask = c; regSysOn = on; regSysOff = off;
    @(negedge clk);
    regWrEn = 1'b0; regSetMask = '0; regClrMask = '0; regSysOn = 1'b0; regSysOff = 1'b0;
    #1;
  endtask

  task automatic assignDev(int d, int l);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDev = 3'(d); cfgLevel = 3'(l);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
  endtask

  task automatic drive(logic [7:0] r);
    @(negedge clk);
    devReq = r;
    #1;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
    #1;
  endtask

  task automatic pulseDismiss();
    @(negedge clk);
    dismissStrobe = 1'b1;
    @(negedge clk);
    dismissStrobe = 1'b0;
    #1;
  endtask

  task automatic tReset();
    chk("R1", "mask", regMask, 8'h01);
    chk("R1", "hold", regHold, 0);
    chk("R1", "sysEn", regSysEn, 0);
    drive(8'hFF);
    chk("R1", "pending with all devices at level 0", intPending, 0);
    drive(8'h00);
  endtask

  task automatic tMaskWrite();
    regWrite(8'hFE, 8'h00, 1'b0, 1'b0);
    chk("R11", "mask after set all", regMask, 8'hFF);
    regWrite(8'h00, 8'hFF, 1'b0, 1'b0);
    chk("R2", "mask after clear all keeps bit0", regMask, 8'h01);
    regWrite(8'hF0, 8'h30, 1'b0, 1'b0);
    chk("R10", "clear wins on shared bits", regMask, 8'hC1);
    regWrite(8'h00, 8'h00, 1'b1, 1'b1);
    chk("R10", "off wins over on", regSysEn, 0);
    regWrite(8'h00, 8'h00, 1'b1, 1'b0);
    chk("R11", "sysEn after on", regSysEn, 1);
    regWrite(8'hFE, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic tDisconnect();
    drive(8'h01);
    chk("R3", "level-0 device pending", intPending, 0);
    assignDev(0, 5);
    chk("R3", "routed device pending", intPending, 1);
    chk("R3", "routed device level", intLevel, 5);
    chk("R6", "addr for level 5", intAddr, 42);
    assignDev(0, 0);
    chk("R3", "pending after disconnect", intPending, 0);
    drive(8'h00);
  endtask

  task automatic tShare();
    assignDev(1, 3);
    assignDev(2, 3);
    drive(8'h02);
    chk("R4", "first sharer level", intLevel, 3);
    chk("R4", "first sharer pending", intPending, 1);
    drive(8'h04);
    chk("R4", "second sharer pending", intPending, 1);
    drive(8'h00);
    chk("R4", "no sharer pending", intPending, 0);
  endtask

  task automatic tRecognize();
    assignDev(3, 4);
    drive(8'h08);
    chk("R5", "enabled level 4 pending", intPending, 1);
    regWrite(8'h00, 8'h00, 1'b0, 1'b1);
    chk("R5", "pending with system off", intPending, 0);
    regWrite(8'h00, 8'h10, 1'b1, 1'b0);
    chk("R5", "pending with level masked", intPending, 0);
    regWrite(8'h10, 8'h00, 1'b0, 1'b0);
    chk("R5", "pending after unmask", intPending, 1);
    drive(8'h00);
  endtask

  task automatic tPriority();
    assignDev(4, 6);
    assignDev(5, 2);
    drive(8'h30);
    chk("R6", "winner of 6 and 2", intLevel, 2);
    chk("R6", "addr for level 2", intAddr, 36);
    drive(8'h10);
    chk("R6", "lone level 6", intLevel, 6);
    chk("R6", "addr for level 6", intAddr, 44);
    drive(8'h00);
  endtask

  task automatic tNest();
    // dev3=level4, dev4=level6, dev5=level2
    pulseAck();
    chk("R7", "ack with nothing pending", regHold, 0);
    pulseDismiss();
    chk("R9", "dismiss with nothing held", regHold, 0);
    drive(8'h08);
    pulseAck();
    chk("R7", "hold after ack of 4", regHold, 8'h10);
    chk("R8", "held level blocks itself", intPending, 0);
    drive(8'h18);
    chk("R8", "lower level blocked", intPending, 0);
    drive(8'h38);
    chk("R8", "higher level passes", intPending, 1);
    chk("R8", "higher level id", intLevel, 2);
    pulseAck();
    chk("R7", "nested hold", regHold, 8'h14);
    chk("R8", "all blocked when nested", intPending, 0);
    pulseDismiss();
    chk("R9", "dismiss clears top only", regHold, 8'h10);
    chk("R9", "level 2 raised again", intLevel, 2);
    drive(8'h18);
    chk("R9", "level 4 still held", intPending, 0);
    pulseDismiss();
    chk("R9", "second dismiss", regHold, 0);
    chk("R9", "level 4 winner after unwind", intLevel, 4);
    drive(8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tMaskWrite();
    tDisconnect();
    tShare();
    tRecognize();
    tPriority();
    tNest();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule